// File: doc/BRIEF.md
# Dual-buffer DMA channel controller

This block is a single peripheral DMA channel. Software describes up to two buffers, A and B, each with its own start address and byte count. The channel works through the buffer in use one burst at a time on a memory-side request/acknowledge port. It paces every burst against a ready signal from one peripheral FIFO, and it answers each accepted burst with a one-cycle acknowledge to that FIFO. A configuration register gives the peripheral address, the transfer direction, the data width, the burst length and the byte order.

All control and status lives in one 8-bit control/status word. Software never writes it directly. Three register slots read the word, set its bits (a 1 sets the bit) and clear its bits (a 1 clears the bit). When the buffer in use runs out, the channel marks it done, flips the buffer-in-use bit and moves straight on to the other buffer if that buffer is armed. Software can therefore keep one buffer queued behind the one that is moving. A memory bus error stops the channel and raises a sticky error flag. An interrupt line reports done buffers and errors.

Top module: `dmach_top`

## Requirements
- R1: The control/status word holds run in bit 0, interrupt enable in bit 1, error in bit 2, done-A in bit 3, start-A in bit 4, done-B in bit 5, start-B in bit 6 and buffer-in-use in bit 7 (0 selects A, 1 selects B). It reads zero-extended at register index 0, and indexes 1 and 2 read the same value. After reset the word is 0, irq is low, chan_idle is high and mem_req is low.
- R2: A write to index 1 sets every word bit whose data bit is 1. A write to index 2 clears every such bit. Data bits that are 0 leave the word unchanged. Writing 0xFF to index 2 clears all eight bits.
- R3: The configuration register at index 3 keeps data bits 31:8 as the peripheral address (on dev_sel), bit 4 as the direction (1 means peripheral to memory, driven on mem_we), bit 3 as the data width (dev_wide), bit 2 as the burst length (mem_burst8) and bit 1 as big-endian order (dev_bigend). Every other bit reads 0.
- R4: Indexes 4 and 5 hold the start address and byte count of buffer A, and indexes 6 and 7 hold those of buffer B. Each reads back what was last written to it, or what the channel has advanced it to.
- R5: A burst is 4 bytes when the burst-length bit is 0 and 8 bytes when it is 1. mem_addr is the current address of the buffer in use. Each accepted burst (mem_req and mem_ack high at the same edge) adds the burst length to that buffer's address. It also lowers that buffer's count by the burst length, stopping at 0. A buffer of N bytes therefore takes ceil(N / burst length) bursts.
- R6: When the count of the buffer in use reaches 0, or when that buffer is found armed with a count of 0, the channel clears its start flag, sets its done flag and flips buffer-in-use.
- R7: If the other buffer is armed with a nonzero count when the current buffer finishes, its first burst is requested in the very next cycle, so the two buffers' bursts form one unbroken run.
- R8: While running, if the buffer in use is not armed but the other buffer is, the channel flips buffer-in-use and serves the other buffer.
- R9: No burst is requested while run is clear or while dev_rdy is low.
- R10: A burst answered by mem_err sets the error flag and clears run. It leaves the address and count unchanged. The error flag stays set until it is cleared through index 2.
- R11: irq is high exactly while interrupt enable is set and at least one of done-A, done-B or error is set.
- R12: chan_idle is high exactly when start-A and start-B are both clear. The channel is fully occupied when run, start-A and start-B are all set.
- R13: Once raised, mem_req and mem_addr hold steady until mem_ack or mem_err arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Burst request to memory |
| mem_we | output | 1 | Burst writes memory (peripheral to memory) |
| mem_addr | output | ADDR_W | Burst memory address |
| mem_burst8 | output | 1 | Burst is 8 bytes (else 4) |
| mem_ack | input | 1 | Memory accepted the burst |
| mem_err | input | 1 | Memory reported a bus error for the burst |
| dev_rdy | input | 1 | Peripheral FIFO can take or give a burst |
| dev_ack | output | 1 | One-cycle pulse for each completed burst |
| dev_sel | output | 24 | Peripheral address from configuration |
| dev_wide | output | 1 | Peripheral data width from configuration |
| dev_bigend | output | 1 | Peripheral byte order from configuration |
| chan_idle | output | 1 | Neither buffer armed |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every byte count from 0 to 20 under both burst lengths and both directions. This catches a channel that rounds the burst count wrongly, that hangs or moves data on a zero-length buffer, or that leaves the count above zero after a short final burst. A two-buffer run is timed edge to edge, so a design that spends an idle cycle between A and B would show a gap. Arming only the buffer not in use would strand a design that never swaps. An error is injected mid-transfer to expose a run bit that survives, an address that advances anyway, or an error flag that clears itself. Holding mem_ack low shows whether the request drops or its address moves before acceptance.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam int unsigned CSR_W   = 8;
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_IE    = 1;
  localparam int unsigned B_ERR   = 2;
  localparam int unsigned B_DONEA = 3;
  localparam int unsigned B_STA   = 4;
  localparam int unsigned B_DONEB = 5;
  localparam int unsigned B_STB   = 6;
  localparam int unsigned B_BIU   = 7;

  localparam logic [2:0] RI_CSR   = 3'd0;
  localparam logic [2:0] RI_SET   = 3'd1;
  localparam logic [2:0] RI_CLR   = 3'd2;
  localparam logic [2:0] RI_CFG   = 3'd3;
  localparam logic [2:0] RI_A_ADR = 3'd4;
  localparam logic [2:0] RI_A_CNT = 3'd5;
  localparam logic [2:0] RI_B_ADR = 3'd6;
  localparam logic [2:0] RI_B_CNT = 3'd7;

  typedef struct packed {
    logic [23:0] dev;
    logic        dir;
    logic        wide;
    logic        burst8;
    logic        bigend;
  } chan_cfg_t;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_BUSY = 1'b1} seq_state_e;

endpackage

// File: rtl/dmach_csr.sv
module dmach_csr
  import dmach_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [CSR_W-1:0] wbits,
  input  logic             done_evt,
  input  logic             err_evt,
  input  logic             swap_evt,
  output logic [CSR_W-1:0] csr_o,
  output logic             irq_o
);

  logic [CSR_W-1:0] csr_q;
  logic [CSR_W-1:0] hw_nxt;
  logic [CSR_W-1:0] csr_nxt;
  logic             csr_en;

  // channel events first, software aliases applied on top
  always_comb begin
    hw_nxt = csr_q;
    if (done_evt) begin
      if (csr_q[B_BIU]) begin
        hw_nxt[B_STB]   = 1'b0;
        hw_nxt[B_DONEB] = 1'b1;
      end else begin
        hw_nxt[B_STA]   = 1'b0;
        hw_nxt[B_DONEA] = 1'b1;
      end
      hw_nxt[B_BIU] = ~csr_q[B_BIU];
    end
    if (swap_evt) hw_nxt[B_BIU] = ~csr_q[B_BIU];
    if (err_evt) begin
      hw_nxt[B_ERR] = 1'b1;
      hw_nxt[B_RUN] = 1'b0;
    end
    csr_nxt = hw_nxt;
    if (clr_we) csr_nxt = csr_nxt & ~wbits;
    if (set_we) csr_nxt = csr_nxt | wbits;
    csr_en = set_we | clr_we | done_evt | err_evt | swap_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= '0;
    else if (csr_en) csr_q <= csr_nxt;
  end

  assign csr_o = csr_q;
  assign irq_o = csr_q[B_IE] & (csr_q[B_DONEA] | csr_q[B_DONEB] | csr_q[B_ERR]);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q[B_ERR] && !(clr_we && wbits[B_ERR])) |=> csr_q[B_ERR]);

  a_r6_done_flips_biu: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !set_we && !clr_we) |=> (csr_q[B_BIU] != $past(csr_q[B_BIU])));

  a_r2_zero_write_noop: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_we || clr_we) && wbits == '0 && !done_evt && !err_evt && !swap_evt)
      |=> $stable(csr_q));

endmodule

// File: rtl/dmach_buf.sv
module dmach_buf #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adr_we,
  input  logic              cnt_we,
  input  logic [ADDR_W-1:0] adr_wdata,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              step,
  input  logic [3:0]        blen,
  output logic [ADDR_W-1:0] adr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              last_o,
  output logic              zero_o
);

  localparam int unsigned AP = ADDR_W - 4;
  localparam int unsigned CP = CNT_W - 4;

  logic [ADDR_W-1:0] adr_q, adr_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [CNT_W-1:0]  blen_c;
  logic              adr_en, cnt_en;

  always_comb begin
    blen_c  = {{CP{1'b0}}, blen};
    last_o  = (cnt_q <= blen_c);
    zero_o  = (cnt_q == '0);
    adr_en  = adr_we | step;
    cnt_en  = cnt_we | step;
    adr_nxt = adr_we ? adr_wdata : adr_q + {{AP{1'b0}}, blen};
    if (cnt_we)      cnt_nxt = cnt_wdata;
    else if (last_o) cnt_nxt = '0;
    else             cnt_nxt = cnt_q - blen_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      adr_q <= '0;
    else if (adr_en) adr_q <= adr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign adr_o = adr_q;
  assign cnt_o = cnt_q;

  a_r5_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
  import dmach_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic start_cur,
  input  logic start_oth,
  input  logic zero_cur,
  input  logic last_cur,
  input  logic zero_oth,
  input  logic dev_rdy,
  input  logic mem_ack,
  input  logic mem_err,
  output logic mem_req,
  output logic dev_ack,
  output logic step,
  output logic done_evt,
  output logic err_evt,
  output logic swap_evt
);

  seq_state_e st_q, st_nxt;

  always_comb begin
    st_nxt   = st_q;
    step     = 1'b0;
    dev_ack  = 1'b0;
    done_evt = 1'b0;
    err_evt  = 1'b0;
    swap_evt = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (run) begin
          if (start_cur) begin
            if (zero_cur)     done_evt = 1'b1;
            else if (dev_rdy) st_nxt   = SQ_BUSY;
          end else if (start_oth) begin
            swap_evt = 1'b1;
          end
        end
      end
      SQ_BUSY: begin
        if (mem_err) begin
          err_evt = 1'b1;
          st_nxt  = SQ_IDLE;
        end else if (mem_ack) begin
          step    = 1'b1;
          dev_ack = 1'b1;
          if (last_cur) begin
            done_evt = 1'b1;
            st_nxt   = (run && dev_rdy && start_oth && !zero_oth) ? SQ_BUSY : SQ_IDLE;
          end else if (!(run && dev_rdy)) begin
            st_nxt = SQ_IDLE;
          end
        end
      end
      default: st_nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_nxt;
  end

  assign mem_req = (st_q == SQ_BUSY);

  a_r9_req_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> ($past(run) && $past(dev_rdy)));

  a_r13_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> mem_req);

endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_burst8,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic              dev_rdy,
  output logic              dev_ack,
  output logic [23:0]       dev_sel,
  output logic              dev_wide,
  output logic              dev_bigend,
  output logic              chan_idle,
  output logic              irq
);

  localparam int unsigned NBUF = 2;

  // reset: asserted at once, released through two flops
  logic rst_s0, rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_i = rst_s1;

  // configuration register
  chan_cfg_t cfg_q, cfg_nxt;
  logic      cfg_en;
  always_comb begin
    cfg_en  = reg_we && (reg_addr == RI_CFG);
    cfg_nxt = '{dev: reg_wdata[31:8], dir: reg_wdata[4], wide: reg_wdata[3],
                burst8: reg_wdata[2], bigend: reg_wdata[1]};
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_nxt;
  end

  // control/status word
  logic [CSR_W-1:0] csr;
  logic done_evt, err_evt, swap_evt, seq_step;

  dmach_csr u_csr (
    .clk      (clk),
    .rst_n    (rst_i),
    .set_we   (reg_we && reg_addr == RI_SET),
    .clr_we   (reg_we && reg_addr == RI_CLR),
    .wbits    (reg_wdata[CSR_W-1:0]),
    .done_evt (done_evt),
    .err_evt  (err_evt),
    .swap_evt (swap_evt),
    .csr_o    (csr),
    .irq_o    (irq)
  );

  // buffer descriptors
  logic [3:0]        blen;
  logic [ADDR_W-1:0] b_adr  [NBUF];
  logic [CNT_W-1:0]  b_cnt  [NBUF];
  logic [NBUF-1:0]   b_last, b_zero;
  logic              biu;

  assign blen = cfg_q.burst8 ? 4'd8 : 4'd4;
  assign biu  = csr[B_BIU];

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    localparam logic [2:0] IDX_ADR = 3'(4 + 2 * g);
    localparam logic [2:0] IDX_CNT = 3'(5 + 2 * g);
    dmach_buf #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_i),
      .adr_we    (reg_we && reg_addr == IDX_ADR),
      .cnt_we    (reg_we && reg_addr == IDX_CNT),
      .adr_wdata (reg_wdata[ADDR_W-1:0]),
      .cnt_wdata (reg_wdata[CNT_W-1:0]),
      .step      (seq_step && (biu == 1'(g))),
      .blen      (blen),
      .adr_o     (b_adr[g]),
      .cnt_o     (b_cnt[g]),
      .last_o    (b_last[g]),
      .zero_o    (b_zero[g])
    );
  end

  // sequencer
  logic start_a, start_b, start_cur, start_oth;
  assign start_a   = csr[B_STA];
  assign start_b   = csr[B_STB];
  assign start_cur = biu ? start_b : start_a;
  assign start_oth = biu ? start_a : start_b;

  dmach_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_i),
    .run       (csr[B_RUN]),
    .start_cur (start_cur),
    .start_oth (start_oth),
    .zero_cur  (b_zero[biu]),
    .last_cur  (b_last[biu]),
    .zero_oth  (b_zero[~biu]),
    .dev_rdy   (dev_rdy),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_req   (mem_req),
    .dev_ack   (dev_ack),
    .step      (seq_step),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .swap_evt  (swap_evt)
  );

  assign mem_addr   = b_adr[biu];
  assign mem_we     = cfg_q.dir;
  assign mem_burst8 = cfg_q.burst8;
  assign dev_sel    = cfg_q.dev;
  assign dev_wide   = cfg_q.wide;
  assign dev_bigend = cfg_q.bigend;
  assign chan_idle  = ~(start_a | start_b);

  // register read
  always_comb begin
    unique case (reg_addr)
      RI_CSR, RI_SET, RI_CLR: reg_rdata = 32'(csr);
      RI_CFG:   reg_rdata = {cfg_q.dev, 3'b000, cfg_q.dir, cfg_q.wide,
                             cfg_q.burst8, cfg_q.bigend, 1'b0};
      RI_A_ADR: reg_rdata = 32'(b_adr[0]);
      RI_A_CNT: reg_rdata = 32'(b_cnt[0]);
      RI_B_ADR: reg_rdata = 32'(b_adr[1]);
      default:  reg_rdata = 32'(b_cnt[1]);
    endcase
  end

  a_r10_error_stops_run: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req && mem_err && !reg_we) |=> !csr[B_RUN]);

  a_r13_addr_held: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_req && !mem_ack && !mem_err && !reg_we) |=> $stable(mem_addr));

endmodule

// File: tb/test_dmach_top.sv
module test_dmach_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_burst8, mem_ack, mem_err;
  logic [31:0] mem_addr;
  logic        dev_rdy, dev_ack, dev_wide, dev_bigend, chan_idle, irq;
  logic [23:0] dev_sel;
  logic        ack_hold, err_inj;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // monitor state
  int          cyc = 0;
  int          bursts = 0;
  int          first_cyc = 0;
  int          last_cyc = 0;
  bit          req_seen = 1'b0;
  logic [31:0] mon_b0, mon_b1;
  int          mon_n0;
  int          mon_bl;
  logic        mon_we;

  always #5 clk = ~clk;

  assign mem_ack = mem_req & ~ack_hold & ~err_inj;
  assign mem_err = mem_req & err_inj;

  dmach_top i_dmach_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_burst8(mem_burst8),
    .mem_ack(mem_ack), .mem_err(mem_err), .dev_rdy(dev_rdy), .dev_ack(dev_ack),
    .dev_sel(dev_sel), .dev_wide(dev_wide), .dev_bigend(dev_bigend),
    .chan_idle(chan_idle), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // burst monitor, sampled on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && mem_req) req_seen = 1'b1;
    if (rst_n && mem_req && mem_ack) begin
      logic [31:0] ea;
      ea = (bursts < mon_n0) ? mon_b0 + 32'(bursts * mon_bl)
                             : mon_b1 + 32'((bursts - mon_n0) * mon_bl);
      chk(mem_addr == ea, "R5 burst address", mem_addr, ea);
      chk(mem_we == mon_we, "R3 direction on mem_we", 32'(mem_we), 32'(mon_we));
      chk(dev_ack == 1'b1, "R5 dev_ack on burst", 32'(dev_ack), 32'd1);
      if (bursts == 0) first_cyc = cyc;
      last_cyc = cyc;
      bursts++;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 3'd0;
  endtask

  task automatic mon_reset(input logic [31:0] b0, input int n0, input logic [31:0] b1,
                           input int bl, input logic we);
    mon_b0 = b0; mon_n0 = n0; mon_b1 = b1; mon_bl = bl; mon_we = we;
    bursts = 0; req_seen = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (!chan_idle && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(chan_idle == 1'b1, req, 32'(chan_idle), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base;
    logic        exp_biu;
    int          it;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    dev_rdy = 1; ack_hold = 0; err_inj = 0;
    mon_reset(0, 1000, 0, 4, 0);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd0, v);
    chk(v == 0, "R1 csr after reset", v, 0);
    chk(irq == 0 && chan_idle == 1 && mem_req == 0, "R1 outputs after reset",
        {irq, chan_idle, mem_req}, 32'b010);

    // R3 configuration fields
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v);
    chk(v == 32'hFFFF_FF1E, "R3 config readback", v, 32'hFFFF_FF1E);
    chk({dev_sel, dev_wide, dev_bigend, mem_burst8, mem_we} == {24'hFFFFFF, 4'hF},
        "R3 config outputs", {dev_sel, dev_wide, dev_bigend, mem_burst8, mem_we},
        {24'hFFFFFF, 4'hF});

    // R4 buffer registers
    wr(3'd4, 32'h1234_5678);
    wr(3'd7, 32'h0000_ABCD);
    rd(3'd4, v);
    chk(v == 32'h1234_5678, "R4 buffer A address", v, 32'h1234_5678);
    rd(3'd7, v);
    chk(v == 32'h0000_ABCD, "R4 buffer B count", v, 32'h0000_ABCD);
    wr(3'd7, 0);

    // R2 aliases
    wr(3'd1, 32'h0000_0082);
    rd(3'd1, v);
    chk(v == 32'h82, "R2 set alias", v, 32'h82);
    wr(3'd1, 0);
    wr(3'd2, 0);
    rd(3'd2, v);
    chk(v == 32'h82, "R2 zero writes no effect", v, 32'h82);
    chk(irq == 0, "R11 enable without flags", 32'(irq), 0);
    wr(3'd2, 32'h80);
    rd(3'd0, v);
    chk(v == 32'h02, "R2 clear alias", v, 32'h02);
    wr(3'd1, 32'h7F);
    wr(3'd2, 32'hFF);
    rd(3'd0, v);
    chk(v == 0, "R2 clear all with 0xFF", v, 0);

    // R5 R6 R11 R12 sweep: counts 0..20, both burst lengths, both directions
    exp_biu = 1'b0;
    it = 0;
    for (int bs = 0; bs < 2; bs++) begin
      for (int dr = 0; dr < 2; dr++) begin
        for (int cnt = 0; cnt <= 20; cnt++) begin
          int bl, nb;
          logic [31:0] cfgw, exp_csr;
          bl = bs ? 8 : 4;
          nb = (cnt + bl - 1) / bl;
          base = 32'h0001_0000 + 32'(it * 256);
          cfgw = {24'hA50000 | 24'(it), 3'b000, 1'(dr), 1'b0, 1'(bs), 1'b0, 1'b0};
          wr(3'd3, cfgw);
          wr(exp_biu ? 3'd6 : 3'd4, base);
          wr(exp_biu ? 3'd7 : 3'd5, 32'(cnt));
          mon_reset(base, 1000, 0, bl, 1'(dr));
          wr(3'd1, exp_biu ? 32'h43 : 32'h13);
          wait_idle("R12 idle after buffer");
          chk(bursts == nb, "R5 burst count", 32'(bursts), 32'(nb));
          rd(exp_biu ? 3'd7 : 3'd5, v);
          chk(v == 0, "R5 count reaches zero", v, 0);
          rd(exp_biu ? 3'd6 : 3'd4, v);
          chk(v == base + 32'(nb * bl), "R5 final address", v, base + 32'(nb * bl));
          rd(3'd0, v);
          exp_csr = {~exp_biu, 1'b0, exp_biu, 1'b0, ~exp_biu, 3'b011};
          chk(v == exp_csr, "R6 status after completion", v, exp_csr);
          chk(irq == 1, "R11 irq on done", 32'(irq), 1);
          chk(dev_sel == (24'hA50000 | 24'(it)), "R3 dev_sel", 32'(dev_sel),
              32'(24'hA50000 | 24'(it)));
          wr(3'd2, 32'h28);
          chk(irq == 0, "R11 irq drops after clear", 32'(irq), 0);
          exp_biu = ~exp_biu;
          it++;
        end
      end
    end

    // R7 R12 ping-pong: both buffers queued, no gap between them
    wr(3'd2, 32'hFF);
    wr(3'd3, 32'h0000_0000);
    dev_rdy = 0;
    wr(3'd4, 32'h0002_0000);
    wr(3'd5, 12);
    wr(3'd6, 32'h0002_0100);
    wr(3'd7, 20);
    mon_reset(32'h0002_0000, 3, 32'h0002_0100, 4, 1'b0);
    wr(3'd1, 32'h53);
    rd(3'd0, v);
    chk((v & 32'h51) == 32'h51, "R12 fully occupied", v & 32'h51, 32'h51);
    chk(chan_idle == 0, "R12 not idle while armed", 32'(chan_idle), 0);
    dev_rdy = 1;
    wait_idle("R7 idle after both buffers");
    chk(bursts == 8, "R7 total bursts", 32'(bursts), 8);
    chk(last_cyc - first_cyc + 1 == 8, "R7 no gap between buffers",
        32'(last_cyc - first_cyc + 1), 8);
    rd(3'd0, v);
    chk(v == 32'h2B, "R7 both done, back on A", v, 32'h2B);

    // R8 arm only the buffer not in use
    wr(3'd2, 32'hFF);
    wr(3'd6, 32'h0003_0000);
    wr(3'd7, 16);
    mon_reset(32'h0003_0000, 1000, 0, 4, 1'b0);
    wr(3'd1, 32'h43);
    wait_idle("R8 idle after swap");
    chk(bursts == 4, "R8 bursts from other buffer", 32'(bursts), 4);
    rd(3'd0, v);
    chk(v == 32'h23, "R8 done-B and buffer-in-use back to A", v, 32'h23);

    // R9 no transfer without run, nor without dev_rdy
    wr(3'd2, 32'hFF);
    wr(3'd4, 32'h0004_0000);
    wr(3'd5, 8);
    mon_reset(32'h0004_0000, 1000, 0, 4, 1'b0);
    wr(3'd1, 32'h10);
    repeat (8) @(negedge clk);
    chk(req_seen == 0, "R9 no request while run clear", 32'(req_seen), 0);
    dev_rdy = 0;
    wr(3'd1, 32'h01);
    repeat (8) @(negedge clk);
    chk(req_seen == 0, "R9 no request while dev_rdy low", 32'(req_seen), 0);
    dev_rdy = 1;
    wait_idle("R9 idle after release");
    chk(bursts == 2, "R9 bursts after release", 32'(bursts), 2);

    // R13 request held without acknowledge
    wr(3'd2, 32'hFF);
    wr(3'd4, 32'h0005_0040);
    wr(3'd5, 4);
    ack_hold = 1;
    mon_reset(32'h0005_0040, 1000, 0, 4, 1'b0);
    wr(3'd1, 32'h13);
    repeat (5) @(negedge clk);
    chk(mem_req == 1, "R13 request held", 32'(mem_req), 1);
    chk(mem_addr == 32'h0005_0040, "R13 address held", mem_addr, 32'h0005_0040);
    ack_hold = 0;
    wait_idle("R13 idle after acknowledge");
    chk(bursts == 1, "R13 one burst", 32'(bursts), 1);

    // R10 bus error
    wr(3'd2, 32'hFF);
    wr(3'd4, 32'h0006_0000);
    wr(3'd5, 16);
    err_inj = 1;
    mon_reset(32'h0006_0000, 1000, 0, 4, 1'b0);
    wr(3'd1, 32'h13);
    repeat (3) @(negedge clk);
    err_inj = 0;
    rd(3'd0, v);
    chk(v == 32'h16, "R10 error set and run cleared", v, 32'h16);
    chk(irq == 1, "R11 irq on error", 32'(irq), 1);
    repeat (6) @(negedge clk);
    chk(mem_req == 0 && bursts == 0, "R10 no transfer after error", 32'(bursts), 0);
    rd(3'd0, v);
    chk(v[2] == 1, "R10 error sticky", 32'(v[2]), 1);
    rd(3'd5, v);
    chk(v == 16, "R10 count unchanged", v, 16);
    rd(3'd4, v);
    chk(v == 32'h0006_0000, "R10 address unchanged", v, 32'h0006_0000);
    wr(3'd2, 32'h14);
    rd(3'd0, v);
    chk(v == 32'h02, "R10 error cleared by alias", v, 32'h02);
    chk(irq == 0 && chan_idle == 1, "R11 irq low after error clear",
        {irq, chan_idle}, 32'b01);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule